// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of virtual-page-to-physical-frame translations that sits beside a processor's load, store and fetch path. Each slot holds a virtual page number, an address-space identifier, a frame number, two permission bits and a "pinned" flag. A lookup compares its page number and identifier with every slot at once, and the registered response on the next clock edge gives hit or miss, the frame number, the permission bits and an access-fault flag. Because each slot carries its owner's identifier, a context switch only changes the identifier on the lookup port, and no invalidation is needed.

On a miss the response raises a request that a separate page-table walker acts on. The walker then installs the translation through the fill port. If a valid slot already holds the same page and identifier, the fill overwrites that slot. Otherwise a round-robin pointer picks the next slot that is not pinned. Pinned slots are never chosen as victims and survive both flush commands. One flush command clears every unpinned slot of one identifier, and the other clears every unpinned slot. `N` must be a power of two and at least 2. The intended range is 64 to 1,024 slots.

Top module: `tlb_asid`

## Requirements
- R1: A lookup (`lkp_valid`=1) is answered on the next clock edge: `rsp_valid`=1, and if a valid slot holds the same page and identifier, `rsp_hit`=1 with that slot's `rsp_pfn` and `rsp_perm`. Without a hit, `rsp_pfn` and `rsp_perm` are 0.
- R2: A slot whose identifier differs from `lkp_asid` never produces a hit, even when the page number matches.
- R3: A lookup that finds no matching slot answers with `rsp_miss`=1 and `rsp_hit`=0. This is the walker request. `rsp_hit`, `rsp_miss` and `rsp_fault` are 0 in cycles after no lookup.
- R4: A fill installs its translation from the next edge onward. A lookup in the same cycle as the fill sees the contents from before the fill.
- R5: A fill whose page and identifier match a valid slot rewrites that slot and does not move the replacement pointer. A slot that was pinned stays pinned.
- R6: Otherwise the fill goes into the first unpinned slot at or after the pointer, searching upward with wrap-around. The pointer then moves to that slot plus one. The pointer is 0 after reset.
- R7: If there is no matching slot and every slot is pinned, the fill changes nothing and `fill_reject`=1 on the next edge. At all other times `fill_reject` is 0.
- R8: `flush_asid_valid` clears every unpinned slot whose identifier equals `flush_asid`. Other slots are kept.
- R9: `flush_all` clears every unpinned slot. Pinned slots keep hitting.
- R10: `lkp_acc` encodes 0 = load, 1 = store, 2 = fetch, 3 = treated as load. `rsp_perm` bit 0 allows stores and bit 1 allows fetch. `rsp_fault`=1 only on a hit where a store meets bit 0 clear or a fetch meets bit 1 clear. Loads never fault.
- R11: After reset, no slot is valid and every response output is 0.
- R12: A flush and a fill in the same cycle: the flush acts first, so the newly filled translation is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_vpn | input | VPN_W | Lookup virtual page number |
| lkp_asid | input | ASID_W | Lookup address-space identifier |
| lkp_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Identifier to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_perm | input | 2 | Bit 0 store allowed, bit 1 fetch allowed |
| fill_wired | input | 1 | Pin the installed slot |
| flush_asid_valid | input | 1 | Clear unpinned slots of one identifier |
| flush_asid | input | ASID_W | Identifier to clear |
| flush_all | input | 1 | Clear all unpinned slots |
| rsp_valid | output | 1 | Response to the previous cycle's lookup |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation absent; walker request |
| rsp_pfn | output | PFN_W | Frame number on hit |
| rsp_perm | output | 2 | Permission bits on hit |
| rsp_fault | output | 1 | Access type not permitted |
| fill_reject | output | 1 | Previous fill dropped, all slots pinned |

## Verification
The assertions assume the control inputs are driven to known values in every cycle. They also assume that `lkp_acc` is sampled in the same cycle as `lkp_valid`, because the fault property relates a response to the access type seen one edge earlier. The bench drives every input from a known idle value at the falling edge, holds all requests low while reset is active, and uses eight slots with a small pool of page numbers and identifiers. With that pool, matches, overwrites, wrap-around, fully pinned rejection and flush collisions all occur often. A random phase resets the block every few hundred cycles so that pinned slots do not build up and freeze replacement.

// File: rtl/tlb_asid_pkg.sv
package tlb_asid_pkg;

    localparam int PERM_W  = 2;
    localparam int PERM_WR = 0;   // store allowed
    localparam int PERM_EX = 1;   // instruction fetch allowed

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_OTHER = 2'd3
    } acc_e;

endpackage

// File: rtl/tlb_asid_cam.sv
// Parallel tag compare: one match line per slot.
module tlb_asid_cam #(
    parameter int N      = 64,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8
) (
    input  logic [N-1:0]             slot_valid,
    input  logic [N-1:0][VPN_W-1:0]  slot_vpn,
    input  logic [N-1:0][ASID_W-1:0] slot_asid,
    input  logic [VPN_W-1:0]         key_vpn,
    input  logic [ASID_W-1:0]        key_asid,
    output logic [N-1:0]             match
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = slot_valid[g]
                       && (slot_vpn[g]  == key_vpn)
                       && (slot_asid[g] == key_asid);
    end

endmodule

// File: rtl/tlb_asid_sel.sv
// AND-OR read of the slot picked by a one-hot (or empty) match vector.
module tlb_asid_sel #(
    parameter int N = 64,
    parameter int W = 8
) (
    input  logic [N-1:0]        onehot,
    input  logic [N-1:0][W-1:0] data,
    output logic                any,
    output logic [W-1:0]        out
);

    always_comb begin
        out = '0;
        for (int i = 0; i < N; i++) begin
            out = out | (data[i] & {W{onehot[i]}});
        end
    end

    assign any = |onehot;

endmodule

// File: rtl/tlb_asid_rr.sv
// First unpinned slot at or after the pointer, with wrap-around.
module tlb_asid_rr #(
    parameter int N = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     pinned,
    input  logic [IDX_W-1:0] ptr,
    output logic             found,
    output logic [IDX_W-1:0] victim
);

    logic [IDX_W-1:0] idx;

    always_comb begin
        found  = 1'b0;
        victim = '0;
        idx    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            idx = ptr + IDX_W'(i);
            if (!pinned[idx]) begin
                found  = 1'b1;
                victim = idx;
            end
        end
    end

endmodule

// File: rtl/tlb_asid.sv
module tlb_asid
    import tlb_asid_pkg::*;
#(
    parameter int N      = 64,
    parameter int VPN_W  = 20,
    parameter int PFN_W  = 20,
    parameter int ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lkp_valid,
    input  logic [VPN_W-1:0]  lkp_vpn,
    input  logic [ASID_W-1:0] lkp_asid,
    input  logic [1:0]        lkp_acc,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [1:0]        fill_perm,
    input  logic              fill_wired,
    input  logic              flush_asid_valid,
    input  logic [ASID_W-1:0] flush_asid,
    input  logic              flush_all,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [PFN_W-1:0]  rsp_pfn,
    output logic [1:0]        rsp_perm,
    output logic              rsp_fault,
    output logic              fill_reject
);

    localparam int IDX_W = $clog2(N);
    localparam int RD_W  = PFN_W + PERM_W;
    localparam int FD_W  = IDX_W + 1;

    typedef struct packed {
        logic [N-1:0]              valid;
        logic [N-1:0]              wired;
        logic [N-1:0][VPN_W-1:0]   vpn;
        logic [N-1:0][ASID_W-1:0]  asid;
        logic [N-1:0][PFN_W-1:0]   pfn;
        logic [N-1:0][PERM_W-1:0]  perm;
        logic [IDX_W-1:0]          ptr;
        logic                      r_valid;
        logic                      r_hit;
        logic                      r_miss;
        logic [PFN_W-1:0]          r_pfn;
        logic [PERM_W-1:0]         r_perm;
        logic                      r_fault;
        logic                      r_reject;
    } state_t;

    state_t s_d, s_q;

    logic [N-1:0]            lk_match, fl_match;
    logic [N-1:0][RD_W-1:0]  rd_data;
    logic [N-1:0][FD_W-1:0]  fd_data;
    logic                    lk_hit, fl_hit;
    logic [RD_W-1:0]         lk_out;
    logic [FD_W-1:0]         fl_out;
    logic                    rr_found;
    logic [IDX_W-1:0]        rr_victim;

    for (genvar g = 0; g < N; g++) begin : g_pack
        assign rd_data[g] = {s_q.pfn[g], s_q.perm[g]};
        assign fd_data[g] = {IDX_W'(g), s_q.wired[g]};
    end

    tlb_asid_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_lkp (
        .slot_valid (s_q.valid),
        .slot_vpn   (s_q.vpn),
        .slot_asid  (s_q.asid),
        .key_vpn    (lkp_vpn),
        .key_asid   (lkp_asid),
        .match      (lk_match)
    );

    tlb_asid_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_fill (
        .slot_valid (s_q.valid),
        .slot_vpn   (s_q.vpn),
        .slot_asid  (s_q.asid),
        .key_vpn    (fill_vpn),
        .key_asid   (fill_asid),
        .match      (fl_match)
    );

    tlb_asid_sel #(.N(N), .W(RD_W)) u_sel_lkp (
        .onehot (lk_match),
        .data   (rd_data),
        .any    (lk_hit),
        .out    (lk_out)
    );

    tlb_asid_sel #(.N(N), .W(FD_W)) u_sel_fill (
        .onehot (fl_match),
        .data   (fd_data),
        .any    (fl_hit),
        .out    (fl_out)
    );

    tlb_asid_rr #(.N(N)) u_rr (
        .pinned (s_q.wired),
        .ptr    (s_q.ptr),
        .found  (rr_found),
        .victim (rr_victim)
    );

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic             wr_pin;
    logic [PERM_W-1:0] hit_perm;

    always_comb begin
        s_d = s_q;

        // Lookup response, taken from pre-update contents.
        hit_perm     = lk_out[PERM_W-1:0];
        s_d.r_valid  = lkp_valid;
        s_d.r_hit    = lkp_valid && lk_hit;
        s_d.r_miss   = lkp_valid && !lk_hit;
        s_d.r_pfn    = s_d.r_hit ? lk_out[RD_W-1:PERM_W] : '0;
        s_d.r_perm   = s_d.r_hit ? hit_perm : '0;
        s_d.r_fault  = s_d.r_hit &&
                       (((acc_e'(lkp_acc) == ACC_STORE) && !hit_perm[PERM_WR]) ||
                        ((acc_e'(lkp_acc) == ACC_FETCH) && !hit_perm[PERM_EX]));
        s_d.r_reject = 1'b0;

        // Flushes act before a same-cycle fill.
        for (int i = 0; i < N; i++) begin
            if (!s_q.wired[i] &&
                (flush_all || (flush_asid_valid && (s_q.asid[i] == flush_asid)))) begin
                s_d.valid[i] = 1'b0;
            end
        end

        // Fill target: existing tag first, else round-robin victim.
        wr_en  = 1'b0;
        wr_idx = '0;
        wr_pin = fill_wired;
        if (fill_valid) begin
            if (fl_hit) begin
                wr_en  = 1'b1;
                wr_idx = fl_out[FD_W-1:1];
                wr_pin = fill_wired | fl_out[0];
            end else if (rr_found) begin
                wr_en   = 1'b1;
                wr_idx  = rr_victim;
                s_d.ptr = rr_victim + 1'b1;
            end else begin
                s_d.r_reject = 1'b1;
            end
        end

        if (wr_en) begin
            s_d.valid[wr_idx] = 1'b1;
            s_d.wired[wr_idx] = wr_pin;
            s_d.vpn[wr_idx]   = fill_vpn;
            s_d.asid[wr_idx]  = fill_asid;
            s_d.pfn[wr_idx]   = fill_pfn;
            s_d.perm[wr_idx]  = fill_perm;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid   = s_q.r_valid;
    assign rsp_hit     = s_q.r_hit;
    assign rsp_miss    = s_q.r_miss;
    assign rsp_pfn     = s_q.r_pfn;
    assign rsp_perm    = s_q.r_perm;
    assign rsp_fault   = s_q.r_fault;
    assign fill_reject = s_q.r_reject;

endmodule

// File: rtl/tlb_asid_chk.sv
module tlb_asid_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lkp_valid,
    input logic [1:0] lkp_acc,
    input logic       fill_valid,
    input logic       rsp_valid,
    input logic       rsp_hit,
    input logic       rsp_miss,
    input logic [1:0] rsp_perm,
    input logic       rsp_fault,
    input logic       fill_reject
);

    p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lkp_valid));

    p_hit_xor_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit ^ rsp_miss));

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

    p_fault_needs_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_hit);

    p_store_readonly_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && ($past(lkp_acc) == 2'd1) && !rsp_perm[0]) |-> rsp_fault);

    p_reject_needs_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_reject |-> $past(fill_valid));

endmodule

bind tlb_asid tlb_asid_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lkp_valid   (lkp_valid),
    .lkp_acc     (lkp_acc),
    .fill_valid  (fill_valid),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_miss    (rsp_miss),
    .rsp_perm    (rsp_perm),
    .rsp_fault   (rsp_fault),
    .fill_reject (fill_reject)
);

// File: tb/tlb_asid_tb.sv
module tlb_asid_tb;

    localparam int N      = 8;
    localparam int VPN_W  = 12;
    localparam int PFN_W  = 16;
    localparam int ASID_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lkp_valid = 0;
    logic [VPN_W-1:0]  lkp_vpn = '0;
    logic [ASID_W-1:0] lkp_asid = '0;
    logic [1:0]        lkp_acc = '0;
    logic              fill_valid = 0;
    logic [VPN_W-1:0]  fill_vpn = '0;
    logic [ASID_W-1:0] fill_asid = '0;
    logic [PFN_W-1:0]  fill_pfn = '0;
    logic [1:0]        fill_perm = '0;
    logic              fill_wired = 0;
    logic              flush_asid_valid = 0;
    logic [ASID_W-1:0] flush_asid = '0;
    logic              flush_all = 0;
    logic              rsp_valid, rsp_hit, rsp_miss, rsp_fault, fill_reject;
    logic [PFN_W-1:0]  rsp_pfn;
    logic [1:0]        rsp_perm;

    always #2.5 clk = ~clk;

    tlb_asid #(.N(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_dut (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural model
    bit m_valid[N];
    bit m_wired[N];
    int m_vpn[N], m_asid[N], m_pfn[N], m_perm[N];
    int m_ptr;

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_wired[i] = 0;
            m_vpn[i] = 0; m_asid[i] = 0; m_pfn[i] = 0; m_perm[i] = 0;
        end
        m_ptr = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        lkp_valid = 0; fill_valid = 0; flush_all = 0; flush_asid_valid = 0;
        repeat (2) @(posedge clk);
        model_clear();
        @(negedge clk);
        rst_n = 1;
        checks++;
        if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_miss !== 0 || rsp_fault !== 0 ||
            fill_reject !== 0 || rsp_pfn !== 0 || rsp_perm !== 0) begin
            fails++;
            $display("FAIL R11: outputs after reset v%0b h%0b m%0b f%0b rj%0b pfn%0h, expected all 0",
                     rsp_valid, rsp_hit, rsp_miss, rsp_fault, fill_reject, rsp_pfn);
        end
    endtask

    // One cycle: drive at negedge, predict, compare at next negedge.
    task automatic step(input string tag,
                        input bit lv, input int lvpn, input int lasid, input int lacc,
                        input bit fv, input int fvpn, input int fasid, input int fpfn,
                        input int fperm, input bit fw,
                        input bit fa, input bit fav, input int fas);
        bit e_h, e_f, e_rj;
        int e_pfn, e_perm, midx, tgt;
        bit pin;
        lkp_valid = lv; lkp_vpn = VPN_W'(lvpn); lkp_asid = ASID_W'(lasid); lkp_acc = 2'(lacc);
        fill_valid = fv; fill_vpn = VPN_W'(fvpn); fill_asid = ASID_W'(fasid);
        fill_pfn = PFN_W'(fpfn); fill_perm = 2'(fperm); fill_wired = fw;
        flush_all = fa; flush_asid_valid = fav; flush_asid = ASID_W'(fas);

        e_h = 0; e_pfn = 0; e_perm = 0;
        for (int i = 0; i < N; i++)
            if (lv && m_valid[i] && m_vpn[i] == lvpn && m_asid[i] == lasid) begin
                e_h = 1; e_pfn = m_pfn[i]; e_perm = m_perm[i];
            end
        e_f = e_h && ((lacc == 1 && (e_perm & 1) == 0) || (lacc == 2 && (e_perm & 2) == 0));

        e_rj = 0; tgt = -1; pin = fw;
        if (fv) begin
            midx = -1;
            for (int i = 0; i < N; i++)
                if (m_valid[i] && m_vpn[i] == fvpn && m_asid[i] == fasid) midx = i;
            if (midx >= 0) begin
                tgt = midx; pin = fw | m_wired[midx];
            end else begin
                for (int k = 0; k < N && tgt < 0; k++)
                    if (!m_wired[(m_ptr + k) % N]) tgt = (m_ptr + k) % N;
                if (tgt < 0) e_rj = 1;
                else m_ptr = (tgt + 1) % N;
            end
        end
        for (int i = 0; i < N; i++)
            if (!m_wired[i] && (fa || (fav && m_asid[i] == fas))) m_valid[i] = 0;
        if (tgt >= 0) begin
            m_valid[tgt] = 1; m_wired[tgt] = pin; m_vpn[tgt] = fvpn;
            m_asid[tgt] = fasid; m_pfn[tgt] = fpfn; m_perm[tgt] = fperm;
        end

        @(posedge clk);
        @(negedge clk);
        checks++;
        if (rsp_valid !== lv || rsp_hit !== e_h || rsp_miss !== (lv && !e_h) ||
            rsp_fault !== e_f || fill_reject !== e_rj ||
            rsp_pfn !== PFN_W'(e_pfn) || rsp_perm !== 2'(e_perm)) begin
            fails++;
            $display("FAIL %s: got v%0b h%0b m%0b f%0b rj%0b pfn%0h perm%0h, expected v%0b h%0b m%0b f%0b rj%0b pfn%0h perm%0h",
                     tag, rsp_valid, rsp_hit, rsp_miss, rsp_fault, fill_reject, rsp_pfn, rsp_perm,
                     lv, e_h, lv && !e_h, e_f, e_rj, e_pfn[PFN_W-1:0], e_perm[1:0]);
        end
    endtask

    task automatic look(input string tag, input int vpn, input int asid, input int acc);
        step(tag, 1, vpn, asid, acc, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic put(input string tag, input int vpn, input int asid, input int pfn,
                       input int perm, input bit w);
        step(tag, 0, 0, 0, 0, 1, vpn, asid, pfn, perm, w, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();
        look("R11", 5, 1, 0);
        look("R3", 5, 1, 0);
        // R4: lookup alongside fill sees old contents, then the new one
        step("R4", 1, 5, 1, 0, 1, 5, 1, 'h55, 3, 0, 0, 0, 0);
        look("R1", 5, 1, 0);
        look("R2", 5, 2, 0);
        // R5: same tag overwrites in place
        put("R5", 5, 1, 'h66, 3, 0);
        look("R5", 5, 1, 0);
        for (int v = 10; v < 17; v++) put("R6", v, 1, 'h100 + v, 3, 0);
        look("R6", 10, 1, 0);
        look("R6", 5, 1, 0);
        put("R6", 20, 1, 'h120, 3, 0);   // wraps to slot 0, evicting page 5
        look("R6", 5, 1, 0);
        look("R6", 20, 1, 0);
        look("R6", 11, 1, 0);
        // R10: permissions
        put("R10", 30, 1, 'h30, 0, 0);
        look("R10", 30, 1, 1);
        look("R10", 30, 1, 2);
        look("R10", 30, 1, 0);
        look("R10", 30, 1, 3);
        put("R10", 31, 1, 'h31, 3, 0);
        look("R10", 31, 1, 1);
        look("R10", 31, 1, 2);
        // R8: flush by identifier
        put("R8", 40, 2, 'h40, 1, 0);
        step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        look("R8", 40, 2, 0);
        look("R8", 20, 1, 0);
        // R9: flush all keeps pinned
        put("R9", 50, 1, 'h50, 2, 1);
        step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        look("R9", 50, 1, 2);
        look("R9", 40, 2, 0);
        step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        look("R9", 50, 1, 0);
        // R12: flush and fill together
        step("R12", 0, 0, 0, 0, 1, 60, 1, 'h60, 3, 0, 1, 0, 0);
        look("R12", 60, 1, 0);
        // R5: unpinned overwrite of pinned slot keeps the pin
        put("R5", 50, 1, 'h51, 3, 0);
        step("R5", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        look("R5", 50, 1, 0);
        // R7: every slot pinned
        do_reset();
        for (int v = 0; v < N; v++) put("R7", 70 + v, 3, 'h700 + v, 3, 1);
        put("R7", 99, 3, 'h999, 3, 0);
        look("R7", 99, 3, 0);
        look("R7", 72, 3, 0);
        put("R7", 73, 3, 'h773, 1, 0);
        look("R7", 73, 3, 0);
        // random phase
        for (int c = 0; c < 3000; c++) begin
            if (c % 300 == 0) do_reset();
            step("R1",
                 ($urandom % 2) == 0, $urandom % 12, $urandom % 3, $urandom % 4,
                 ($urandom % 3) == 0, $urandom % 12, $urandom % 3, $urandom % 65536,
                 $urandom % 4, ($urandom % 24) == 0,
                 ($urandom % 40) == 0, ($urandom % 25) == 0, $urandom % 3);
        end
        step("R3", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule